// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block produces the START, repeated START and STOP conditions that an I2C master places on the open-drain SCL and SDA lines. It drives two pull-low enables and leaves the release of each line to the external pull-up. A small control register holds a 5-bit even count. From that count the block derives the time SCL stays released around a condition (count+1 system cycles) and the setup and hold intervals on either side of the SDA transition (each half of that).

The block is clocked at twice the system rate, so each half-cycle interval is a whole number of block clocks. One phase of a condition lasts exactly count+1 block clocks. A command strobe starts a sequence. While the sequence runs, `busy` is high and further strobes are ignored. A one-cycle `done` pulse marks its end. An independent detector watches either SDA or SCL through a two-flop synchronizer and raises a one-cycle interrupt on the chosen edge. It serves, for example, bus-activity wakeup. A 10-bit-address read uses the restart command after the second address byte, so that the first address byte can be sent again with the read bit set.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset `cfg_rdata` is 8'h04 (count 4, polarity 0, select 0), both line enables are 0 (released), and `busy`, `done`, `cfg_odd_err` and `line_irq` are 0.
- R2: A write with an even count updates the register. Readback places the count in bits [4:0], the edge polarity in bit 5 and the line select in bit 6.
- R3: A write whose bit 0 is 1 (an odd count) leaves the stored count unchanged. It still updates bits 5 and 6, and `cfg_odd_err` is high for the one cycle after the write edge. Later conditions keep the old timing.
- R4: Bit 7 of the register is reserved. A 1 written to it is dropped, and it always reads 0.
- R5: Every phase of a condition lasts count+1 clocks. SCL is therefore released for 2*(count+1) clocks, the release time, across the setup and hold phases.
- R6: START (`cmd_start`) keeps both lines released for the setup phase, then pulls SDA low for the hold phase, then also pulls SCL low. Encoding of the enables: 1 = pull low.
- R7: RESTART (`cmd_restart`) releases SDA with SCL held low for one phase. It then releases SCL for the setup phase, pulls SDA low for the hold phase, and finally pulls SCL low.
- R8: STOP (`cmd_stop`) pulls both lines low for one phase. It then releases SCL for the setup phase, releases SDA for the hold phase, and ends with both lines released.
- R9: `busy` rises on the clock edge that accepts a strobe. It falls on the edge that ends the last phase, and `done` is high for exactly the one cycle after that edge.
- R10: Strobes that arrive while `busy` is high are ignored. Strobes that arrive together while idle follow the priority STOP over RESTART over START.
- R11: The count is captured on the edge that accepts a command. A register write on that same edge affects only later commands.
- R12: `line_irq` watches SDA when bit 6 is 0 and SCL when bit 6 is 1. It fires on falling edges when bit 5 is 0 and on rising edges when bit 5 is 1. It is a one-cycle pulse during the cycle after the second clock edge that follows the line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback |
| cfg_odd_err | output | 1 | One-cycle flag for a rejected odd count |
| cmd_start | input | 1 | START command strobe |
| cmd_restart | input | 1 | Repeated START command strobe |
| cmd_stop | input | 1 | STOP command strobe |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A condition sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| line_irq | output | 1 | One-cycle edge interrupt on the selected line |

## Verification
Two things can land on the same clock edge: a register write and a command strobe. The command must run with the count held before the write. The bench pulses both in one cycle and measures every phase of that condition against the old count. It then runs the next condition and expects the new count. A second collision, a strobe during a running sequence, is provoked several cycles after acceptance. It is judged by checking that the scoreboard sees no extra line transition and no early `done`.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_START   = 2'd1,
    CMD_RESTART = 2'd2,
    CMD_STOP    = 2'd3
  } cond_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PREP  = 2'd1,
    PH_SETUP = 2'd2,
    PH_HOLD  = 2'd3
  } cond_phase_e;

  // Line pull-low enables: 1 pulls the line low, 0 releases it.
  typedef struct packed {
    logic scl;
    logic sda;
  } drive_t;

  // Clocks in one setup or hold phase (the block clock runs at twice the system rate).
  function automatic int half_ticks(int count);
    return count + 1;
  endfunction

  // Clocks that SCL stays released around a condition.
  function automatic int release_ticks(int count);
    return 2 * half_ticks(count);
  endfunction

  function automatic cond_phase_e first_phase(cond_cmd_e c);
    return (c == CMD_START) ? PH_SETUP : PH_PREP;
  endfunction

  function automatic cond_phase_e next_phase(cond_phase_e p);
    case (p)
      PH_PREP:  return PH_SETUP;
      PH_SETUP: return PH_HOLD;
      default:  return PH_IDLE;
    endcase
  endfunction

  // Drive pattern held during a phase; PH_IDLE gives the level left after the sequence.
  function automatic drive_t phase_drive(cond_cmd_e c, cond_phase_e p);
    drive_t d;
    d = '{scl: 1'b0, sda: 1'b0};
    case (c)
      CMD_STOP: begin
        case (p)
          PH_PREP:  d = '{scl: 1'b1, sda: 1'b1};
          PH_SETUP: d = '{scl: 1'b0, sda: 1'b1};
          default:  d = '{scl: 1'b0, sda: 1'b0};
        endcase
      end
      CMD_START, CMD_RESTART: begin
        case (p)
          PH_PREP:  d = '{scl: 1'b1, sda: 1'b0};
          PH_SETUP: d = '{scl: 1'b0, sda: 1'b0};
          PH_HOLD:  d = '{scl: 1'b0, sda: 1'b1};
          default:  d = '{scl: 1'b1, sda: 1'b1};
        endcase
      end
      default: d = '{scl: 1'b0, sda: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/i2c_cond_cfg.sv
module i2c_cond_cfg #(
  parameter int CNT_W     = 5,
  parameter int REG_W     = 8,
  parameter int RESET_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic             edge_pol,
  output logic             line_sel,
  output logic [REG_W-1:0] rdata,
  output logic             odd_err
);

  localparam int POL_BIT = CNT_W;
  localparam int SEL_BIT = CNT_W + 1;

  logic odd_write;
  assign odd_write = we && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= CNT_W'(RESET_CNT);
      edge_pol <= 1'b0;
      line_sel <= 1'b0;
      odd_err  <= 1'b0;
    end else begin
      odd_err <= odd_write;
      if (we) begin
        edge_pol <= wdata[POL_BIT];
        line_sel <= wdata[SEL_BIT];
        if (!wdata[0]) begin
          count <= wdata[CNT_W-1:0];
        end
      end
    end
  end

  // Reserved bits above the select bit are never stored.
  always_comb begin
    rdata              = '0;
    rdata[CNT_W-1:0]   = count;
    rdata[POL_BIT]     = edge_pol;
    rdata[SEL_BIT]     = line_sel;
  end

  // R3: a rejected odd write keeps the timing count
  assert_odd_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    odd_write |=> (count == $past(count)));

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_restart,
  input  logic             cmd_stop,
  input  logic [CNT_W-1:0] count,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done
);

  cond_cmd_e   req;
  cond_cmd_e   cmd_q;
  cond_phase_e phase;
  drive_t      drv_q;
  logic [CNT_W-1:0] timer;
  logic [CNT_W-1:0] cnt_lat;
  logic [CNT_W-1:0] phase_age;
  logic        accept;
  logic        phase_step;
  logic        any_strobe;

  // Priority among simultaneous strobes: STOP, then RESTART, then START.
  always_comb begin
    if (cmd_stop)         req = CMD_STOP;
    else if (cmd_restart) req = CMD_RESTART;
    else if (cmd_start)   req = CMD_START;
    else                  req = CMD_NONE;
  end

  assign any_strobe = cmd_start || cmd_restart || cmd_stop;
  assign accept     = (phase == PH_IDLE) && (req != CMD_NONE);
  assign phase_step = (phase != PH_IDLE) && (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NONE;
      phase   <= PH_IDLE;
      drv_q   <= '{scl: 1'b0, sda: 1'b0};
      timer   <= '0;
      cnt_lat <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cmd_q   <= req;
        cnt_lat <= count;
        phase   <= first_phase(req);
        timer   <= CNT_W'(half_ticks(int'(count)) - 1);
        drv_q   <= phase_drive(req, first_phase(req));
      end else if (phase_step) begin
        phase <= next_phase(phase);
        timer <= CNT_W'(half_ticks(int'(cnt_lat)) - 1);
        drv_q <= phase_drive(cmd_q, next_phase(phase));
        if (phase == PH_HOLD) begin
          done <= 1'b1;
        end
      end else if (phase != PH_IDLE) begin
        timer <= timer - 1'b1;
      end
    end
  end

  // Independent phase-length counter kept for the timing assertion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_age <= '0;
    end else if (accept || phase_step) begin
      phase_age <= '0;
    end else if (phase != PH_IDLE) begin
      phase_age <= phase_age + 1'b1;
    end
  end

  assign scl_oe = drv_q.scl;
  assign sda_oe = drv_q.sda;
  assign busy   = (phase != PH_IDLE);

  // R5: each phase spans count+1 clocks
  assert_phase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_step |-> (int'(phase_age) + 1 == half_ticks(int'(cnt_lat))));

  // R10: strobes during a sequence do not change the running command
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_strobe) |=> (cmd_q == $past(cmd_q)));

  // R9: done marks the fall of busy
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: during START, SDA is pulled low only while SCL is released
  assert_start_sda_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_START) && $rose(sda_oe)) |-> !scl_oe);

endmodule

// File: rtl/i2c_line_edge.sv
module i2c_line_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int N_LINES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic edge_pol,
  input  logic line_sel,
  output logic irq
);

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] fall;

  // Index 0 is SDA, index 1 is SCL, matching the select bit.
  assign raw = {scl_in, sda_in};

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw[i]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign rise[i] = sync_q[SYNC_STAGES-1] && !prev_q;
    assign fall[i] = !sync_q[SYNC_STAGES-1] && prev_q;
  end

  assign irq = edge_pol ? rise[line_sel] : fall[line_sel];

  // R12: the interrupt is a single-cycle pulse while configuration is steady
  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq || !$stable(line_sel) || !$stable(edge_pol)));

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int REG_W       = 8,
  parameter int RESET_CNT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             cfg_odd_err,
  input  logic             cmd_start,
  input  logic             cmd_restart,
  input  logic             cmd_stop,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             line_irq
);

  logic [CNT_W-1:0] count;
  logic             edge_pol;
  logic             line_sel;

  i2c_cond_cfg #(
    .CNT_W     (CNT_W),
    .REG_W     (REG_W),
    .RESET_CNT (RESET_CNT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .count    (count),
    .edge_pol (edge_pol),
    .line_sel (line_sel),
    .rdata    (cfg_rdata),
    .odd_err  (cfg_odd_err)
  );

  i2c_cond_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_restart (cmd_restart),
    .cmd_stop    (cmd_stop),
    .count       (count),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .busy        (busy),
    .done        (done)
  );

  i2c_line_edge #(
    .SYNC_STAGES (SYNC_STAGES),
    .N_LINES     (2)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .edge_pol (edge_pol),
    .line_sel (line_sel),
    .irq      (line_irq)
  );

endmodule

// File: tb/i2c_cond_gen_test.sv
`timescale 1ns/1ps
module i2c_cond_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       cfg_odd_err;
  logic       cmd_start = 1'b0, cmd_restart = 1'b0, cmd_stop = 1'b0;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       scl_oe, sda_oe, busy, done, line_irq;

  always #2.5 clk = ~clk;

  i2c_cond_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_odd_err(cfg_odd_err),
    .cmd_start(cmd_start), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .line_irq(line_irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    int       at;
    bit       is_done;
    bit [1:0] drv;
    int       reqno;
  } exp_t;
  exp_t exp_q[$];
  bit [1:0] model_drv = 2'b00;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int at, bit is_done, bit [1:0] drv, int reqno);
    exp_t e;
    e.at = at; e.is_done = is_done; e.drv = drv; e.reqno = reqno;
    exp_q.push_back(e);
  endtask

  // Monitor: every observed drive change and done pulse must match the queue head.
  bit [1:0] seen_drv = 2'b00;
  task automatic pop_cmp(bit is_done, bit [1:0] drv);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R10", "unexpected event at cycle", cyc, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.is_done == is_done && e.at == cyc && (is_done || e.drv == drv),
            $sformatf("R%0d", e.reqno),
            $sformatf("event kind=%0d drv=%0d (exp kind=%0d drv=%0d) at cycle",
                      is_done, drv, e.is_done, e.drv), cyc, e.at);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ({scl_oe, sda_oe} != seen_drv) pop_cmp(1'b0, {scl_oe, sda_oe});
      if (done) pop_cmp(1'b1, 2'b00);
    end
    seen_drv = {scl_oe, sda_oe};
  end

  // Kind: 1 START, 2 RESTART, 3 STOP. Returns {scl_oe, sda_oe} of a phase; last index = final level.
  function automatic bit [1:0] exp_drv(int kind, int idx);
    bit [1:0] start_t [3] = '{2'b00, 2'b01, 2'b11};
    bit [1:0] rs_t    [4] = '{2'b10, 2'b00, 2'b01, 2'b11};
    bit [1:0] stop_t  [4] = '{2'b11, 2'b01, 2'b00, 2'b00};
    if (kind == 1) return start_t[idx];
    if (kind == 2) return rs_t[idx];
    return stop_t[idx];
  endfunction

  task automatic set_strobe(int kind, logic v);
    if (kind == 1) cmd_start = v;
    else if (kind == 2) cmd_restart = v;
    else if (kind == 3) cmd_stop = v;
  endtask

  // kind: command expected to run; cnt: count it should use; also: strobe in the same cycle;
  // extra: strobe issued while busy; wr: register write in the same cycle (-1 none).
  task automatic run_cmd(int kind, int cnt, int also, int extra, int wr, int reqno);
    int c0, nph, h;
    bit [1:0] d;
    @(negedge clk);
    c0 = cyc;
    set_strobe(kind, 1'b1);
    if (also != 0) set_strobe(also, 1'b1);
    if (wr >= 0) begin cfg_we = 1'b1; cfg_wdata = wr[7:0]; end
    nph = (kind == 1) ? 2 : 3;
    h = cnt + 1;
    for (int k = 0; k <= nph; k++) begin
      d = exp_drv(kind, k);
      if (d != model_drv) push(c0 + 1 + k * h, 1'b0, d, reqno);
      model_drv = d;
    end
    push(c0 + 1 + nph * h, 1'b1, 2'b00, 9);
    @(negedge clk);
    cmd_start = 1'b0; cmd_restart = 1'b0; cmd_stop = 1'b0; cfg_we = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", busy, 1);
    if (extra != 0) begin
      @(negedge clk); set_strobe(extra, 1'b1);
      @(negedge clk); set_strobe(extra, 1'b0);
    end
    while (cyc < c0 + nph * h) @(negedge clk);
    check(busy == 1'b1, "R9", "busy in last cycle", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after last phase", busy, 0);
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [7:0] val, logic [7:0] exp_rd, string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_odd_err == val[0], "R3", "odd flag", cfg_odd_err, val[0]);
    check(cfg_rdata == exp_rd, req, "readback", cfg_rdata, exp_rd);
    @(negedge clk);
    check(cfg_odd_err == 1'b0, "R3", "odd flag cleared", cfg_odd_err, 0);
  endtask

  // line: 0 SDA, 1 SCL
  task automatic irq_probe(int line, logic v, logic expect_pulse);
    @(negedge clk);
    if (line == 0) sda_in = v; else scl_in = v;
    @(negedge clk);
    check(line_irq == 1'b0, "R12", "irq before sync", line_irq, 0);
    @(negedge clk);
    check(line_irq == expect_pulse, "R12", "irq after sync", line_irq, expect_pulse);
    @(negedge clk);
    check(line_irq == 1'b0, "R12", "irq pulse ends", line_irq, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cfg_rdata == 8'h04, "R1", "reset rdata", cfg_rdata, 8'h04);
    check({scl_oe, sda_oe, busy, done, cfg_odd_err, line_irq} == 6'b0, "R1", "reset outputs",
          {scl_oe, sda_oe, busy, done, cfg_odd_err, line_irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cmd(1, 4, 0, 0, -1, 6);           // R6, R5 with count 4
    run_cmd(3, 4, 0, 0, -1, 8);           // R8
    cfg_write(8'h0A, 8'h0A, "R2");        // count 10
    run_cmd(1, 10, 0, 0, -1, 5);          // R5 release time 22 clocks
    run_cmd(2, 10, 0, 0, -1, 7);          // R7
    run_cmd(3, 10, 0, 0, -1, 8);
    cfg_write(8'h67, 8'h6A, "R3");        // odd: count kept, pol/sel updated
    run_cmd(1, 10, 0, 0, -1, 3);          // R3 timing unchanged
    run_cmd(3, 10, 0, 0, -1, 3);
    cfg_write(8'hE6, 8'h66, "R4");        // reserved bit dropped, count 6
    run_cmd(1, 6, 0, 3, -1, 10);          // R10 STOP during START ignored
    run_cmd(3, 6, 0, 1, -1, 10);          // R10 START during STOP ignored
    run_cmd(3, 6, 1, 0, -1, 10);          // R10 priority: STOP wins over START
    run_cmd(2, 6, 1, 0, -1, 10);          // R10 priority: RESTART wins over START
    run_cmd(3, 6, 0, 0, 8'h04, 11);       // R11 write in same cycle, old count 6 used
    check(cfg_rdata == 8'h04, "R11", "write landed", cfg_rdata, 8'h04);
    run_cmd(1, 4, 0, 0, -1, 11);          // R11 next command uses count 4
    run_cmd(3, 4, 0, 0, -1, 11);

    // R12: select 0 (SDA), polarity 0 (falling)
    irq_probe(0, 1'b0, 1'b1);
    irq_probe(0, 1'b1, 1'b0);
    irq_probe(1, 1'b0, 1'b0);
    irq_probe(1, 1'b1, 1'b0);
    cfg_write(8'h64, 8'h64, "R12");       // select SCL, rising
    irq_probe(1, 1'b0, 1'b0);
    irq_probe(1, 1'b1, 1'b1);
    irq_probe(0, 1'b0, 1'b0);
    irq_probe(0, 1'b1, 1'b0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule